// File: doc/BRIEF.md
# Alarm and Periodic Flag Interrupt Unit

This block watches a free-running elapsed-time count and raises two sticky event flags from it. The count has a fractional part that advances at the tick rate (4096 per second with the default 12-bit width) and a 32-bit whole-seconds part. The alarm flag is raised when the seconds part reaches a programmed 32-bit match value. The periodic flag is raised at one of fifteen selectable rates. The slowest of these fires once every 2^21 seconds.

Both flags stay set until software writes a 0 to the matching bit. Each flag has its own interrupt enable. The enabled flags are ORed into a registered, active-low interrupt output. A status byte packs the two flags together with two externally supplied state bits. The counter that produces the count, and the bus decoding that produces the write strobes, live outside this block.

Top module: `aflag_irq_unit`

## Requirements
- R1: On a cycle with `tick`=1 where `sec_cnt` equals `alarm_val`, the alarm flag is set at the next clock edge, provided the comparison at the previous tick was unequal.
- R2: The alarm flag is not set again on later ticks while the count and alarm value stay equal. A pulse on `cnt_wr` re-arms the comparison, so the next tick with equal values sets the flag.
- R3: Rate code 0000 never sets the periodic flag.
- R4: For rate code c from 1 to 15, the periodic flag is set at the edge after a tick on which the lowest N(c) bits of the combined count {`sec_cnt`,`sub_cnt`} are all zero. N is 0,1,2,3,4,5,9,10,11,12,18,24,28,31,33 for c = 1..15. That is 4096 Hz down to 1 Hz for codes 1..10, and periods of 64, 4096, 65536, 524288 and 2097152 s for codes 11..15.
- R5: Both flags are sticky. A cycle with `flag_wr`=1 clears the alarm flag when `flag_wdata[0]`=0 and the periodic flag when `flag_wdata[1]`=0. A 1 in a written bit leaves that flag unchanged. A set condition in the same cycle as a clear wins.
- R6: Clearing the periodic flag has no effect on later matches: the next matching tick sets it again.
- R7: `irq_n` is registered. It is driven low at the edge where (alarm flag AND `alm_ie`) OR (periodic flag AND `per_ie`) becomes true, using the enables present before that edge. It returns high one edge after both enabled flags are cleared or both enables are 0.
- R8: `status` holds `osc_stop` in bit 7, `upd_busy` in bit 6, the periodic flag in bit 1 and the alarm flag in bit 0. Bits 5..2 read 0.
- R9: Synchronous reset clears both flags and drives `irq_n` high.
- R10: Neither flag is set on a cycle without `tick`, even when the count matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Strobe: the count inputs hold a newly incremented value |
| cnt_wr | input | 1 | Strobe: software wrote the count |
| sub_cnt | input | 12 | Fractional-second count |
| sec_cnt | input | 32 | Whole-seconds count |
| alarm_val | input | 32 | Alarm match value |
| alm_ie | input | 1 | Alarm interrupt enable |
| per_ie | input | 1 | Periodic interrupt enable |
| rate_sel | input | 4 | Periodic rate code |
| flag_wr | input | 1 | Status write strobe |
| flag_wdata | input | 2 | Status write data: bit 1 periodic, bit 0 alarm |
| osc_stop | input | 1 | External oscillator-stop state |
| upd_busy | input | 1 | External update-in-progress state |
| alm_flag | output | 1 | Alarm flag |
| per_flag | output | 1 | Periodic flag |
| irq_n | output | 1 | Active-low interrupt |
| status | output | 8 | Packed status byte |

## Verification
Every nonzero rate code is tried with two counts. In the first, the bits below its tap are all zero and the tap bit is one, which must set the flag. In the second, only the bit just below the tap is one, which must not. These pairs tell a correct tap position from one that is off by a single bit. The alarm is tried with a count approaching the value, then held equal over repeated ticks, then with a count write between ticks. This separates equality-edge detection from plain equality. Further patterns cover matches without a tick, a clear in the same cycle as a set, and enable toggling. These show flag state apart from interrupt gating.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

  localparam int RATE_W = 4;
  localparam int NCODES = 1 << RATE_W;

  // Number of low count bits that must be zero for a periodic match.
  // Rates at or above 1 Hz are expressed against the fractional width,
  // slower ones add whole-second bits on top of it.
  function automatic int tap_of(input int code, input int sub_w);
    case (code)
      1:  tap_of = 0;
      2:  tap_of = 1;
      3:  tap_of = 2;
      4:  tap_of = 3;
      5:  tap_of = 4;
      6:  tap_of = 5;
      7:  tap_of = sub_w - 3;
      8:  tap_of = sub_w - 2;
      9:  tap_of = sub_w - 1;
      10: tap_of = sub_w;
      11: tap_of = sub_w + 6;
      12: tap_of = sub_w + 12;
      13: tap_of = sub_w + 16;
      14: tap_of = sub_w + 19;
      15: tap_of = sub_w + 21;
      default: tap_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/aflag_rate_match.sv
module aflag_rate_match #(
  parameter int SUB_W = 12,
  parameter int SEC_W = 32,
  localparam int CNT_W = SUB_W + SEC_W
) (
  input  logic [CNT_W-1:0]            cnt,
  input  logic [aflag_pkg::RATE_W-1:0] rate_sel,
  output logic                        match
);

  logic [aflag_pkg::NCODES-1:0] hit;

  assign hit[0] = 1'b0;

  for (genvar c = 1; c < aflag_pkg::NCODES; c++) begin : g_code
    localparam int TAP = aflag_pkg::tap_of(c, SUB_W);
    if (TAP == 0) begin : g_every
      assign hit[c] = 1'b1;
    end else begin : g_tap
      assign hit[c] = ~|cnt[TAP-1:0];
    end
  end

  assign match = hit[rate_sel];

endmodule

// File: rtl/aflag_alarm.sv
module aflag_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [SEC_W-1:0] sec_cnt,
  input  logic [SEC_W-1:0] alarm_val,
  input  logic             clr,
  output logic             flag_d,
  output logic             flag_q
);

  logic eq_now;
  logic eq_seen;
  logic set_ev;

  assign eq_now = (sec_cnt == alarm_val);
  assign set_ev = tick & eq_now & ~eq_seen;
  assign flag_d = set_ev | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_seen <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (cnt_wr)
        eq_seen <= 1'b0;
      else if (tick)
        eq_seen <= eq_now;
    end
  end

endmodule

// File: rtl/aflag_periodic.sv
module aflag_periodic #(
  parameter int SUB_W = 12,
  parameter int SEC_W = 32,
  localparam int CNT_W = SUB_W + SEC_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [aflag_pkg::RATE_W-1:0] rate_sel,
  input  logic                         clr,
  output logic                         flag_d,
  output logic                         flag_q
);

  logic match;

  aflag_rate_match #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_match (
    .cnt      (cnt),
    .rate_sel (rate_sel),
    .match    (match)
  );

  assign flag_d = (tick & match) | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

endmodule

// File: rtl/aflag_irq_unit.sv
module aflag_irq_unit #(
  parameter int SUB_W = 12,
  parameter int SEC_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         cnt_wr,
  input  logic [SUB_W-1:0]             sub_cnt,
  input  logic [SEC_W-1:0]             sec_cnt,
  input  logic [SEC_W-1:0]             alarm_val,
  input  logic                         alm_ie,
  input  logic                         per_ie,
  input  logic [aflag_pkg::RATE_W-1:0] rate_sel,
  input  logic                         flag_wr,
  input  logic [1:0]                   flag_wdata,
  input  logic                         osc_stop,
  input  logic                         upd_busy,
  output logic                         alm_flag,
  output logic                         per_flag,
  output logic                         irq_n,
  output logic [7:0]                   status
);

  localparam int CNT_W = SUB_W + SEC_W;

  logic [CNT_W-1:0] cnt_all;
  logic alm_clr, per_clr;
  logic alm_d, per_d;
  logic irq_q;

  assign cnt_all = {sec_cnt, sub_cnt};
  assign alm_clr = flag_wr & ~flag_wdata[0];
  assign per_clr = flag_wr & ~flag_wdata[1];

  aflag_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .sec_cnt   (sec_cnt),
    .alarm_val (alarm_val),
    .clr       (alm_clr),
    .flag_d    (alm_d),
    .flag_q    (alm_flag)
  );

  aflag_periodic #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_periodic (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt      (cnt_all),
    .rate_sel (rate_sel),
    .clr      (per_clr),
    .flag_d   (per_d),
    .flag_q   (per_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b1;
    else     irq_q <= ~((alm_d & alm_ie) | (per_d & per_ie));
  end

  assign irq_n  = irq_q;
  assign status = {osc_stop, upd_busy, 4'b0000, per_flag, alm_flag};

endmodule

// File: rtl/aflag_irq_unit_chk.sv
module aflag_irq_unit_chk #(
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [SEC_W-1:0] sec_cnt,
  input logic [SEC_W-1:0] alarm_val,
  input logic             alm_ie,
  input logic             per_ie,
  input logic [3:0]       rate_sel,
  input logic             flag_wr,
  input logic [1:0]       flag_wdata,
  input logic             alm_flag,
  input logic             per_flag,
  input logic             irq_n
);

  p_alarm_cause_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(alm_flag) |-> $past(sec_cnt) == $past(alarm_val));

  p_rate_off_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rate_sel) == 4'd0 && !$past(per_flag) |-> !per_flag);

  p_alm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(alm_flag) && !($past(flag_wr) && !$past(flag_wdata[0]))
    |-> alm_flag);

  p_per_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(per_flag) && !($past(flag_wr) && !$past(flag_wdata[1]))
    |-> per_flag);

  p_irq_combine_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
    irq_n == !((alm_flag && $past(alm_ie)) || (per_flag && $past(per_ie))));

  p_needs_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(tick) |-> !$rose(alm_flag) && !$rose(per_flag));

endmodule

bind aflag_irq_unit aflag_irq_unit_chk #(.SEC_W(SEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .sec_cnt    (sec_cnt),
  .alarm_val  (alarm_val),
  .alm_ie     (alm_ie),
  .per_ie     (per_ie),
  .rate_sel   (rate_sel),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .alm_flag   (alm_flag),
  .per_flag   (per_flag),
  .irq_n      (irq_n)
);

// File: tb/tb_aflag_irq_unit.sv
module tb_aflag_irq_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [11:0] sub_cnt = '0;
  logic [31:0] sec_cnt = '0;
  logic [31:0] alarm_val = 32'hFFFF_FFFF;
  logic        alm_ie = 1'b0;
  logic        per_ie = 1'b0;
  logic [3:0]  rate_sel = 4'd0;
  logic        flag_wr = 1'b0;
  logic [1:0]  flag_wdata = 2'b11;
  logic        osc_stop = 1'b0;
  logic        upd_busy = 1'b0;
  logic        alm_flag, per_flag, irq_n;
  logic [7:0]  status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aflag_irq_unit dut (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .sub_cnt(sub_cnt), .sec_cnt(sec_cnt), .alarm_val(alarm_val),
    .alm_ie(alm_ie), .per_ie(per_ie), .rate_sel(rate_sel),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .osc_stop(osc_stop), .upd_busy(upd_busy),
    .alm_flag(alm_flag), .per_flag(per_flag), .irq_n(irq_n), .status(status)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic write_flags(input logic [1:0] d);
    flag_wr = 1'b1; flag_wdata = d; step(); flag_wr = 1'b0; flag_wdata = 2'b11;
  endtask

  task automatic set_cnt(input logic [43:0] v);
    {sec_cnt, sub_cnt} = v;
  endtask

  function automatic int exp_tap(input int code);
    int t [16] = '{0, 0, 1, 2, 3, 4, 5, 9, 10, 11, 12, 18, 24, 28, 31, 33};
    return t[code];
  endfunction

  task automatic t_reset();
    chk("R9 alm after reset", alm_flag, 0);
    chk("R9 per after reset", per_flag, 0);
    chk("R9 irq_n after reset", irq_n, 1);
  endtask

  task automatic t_alarm();
    alarm_val = 32'd100;
    sec_cnt = 32'd100; sub_cnt = 12'd5;
    step(); step();
    chk("R10 equal without tick", alm_flag, 0);
    sec_cnt = 32'd99; pulse_tick();
    chk("R1 below alarm", alm_flag, 0);
    sec_cnt = 32'd100; pulse_tick();
    chk("R1 equal on tick", alm_flag, 1);
    write_flags(2'b10);
    chk("R5 alarm cleared by 0", alm_flag, 0);
    pulse_tick();
    chk("R2 no retrigger while equal", alm_flag, 0);
    cnt_wr = 1'b1; step(); cnt_wr = 1'b0;
    chk("R2 count write alone", alm_flag, 0);
    pulse_tick();
    chk("R2 re-armed after count write", alm_flag, 1);
    write_flags(2'b01);
    chk("R5 write of 1 keeps alarm", alm_flag, 1);
    write_flags(2'b00);
    alarm_val = 32'hFFFF_FFFF;
  endtask

  task automatic t_rates();
    rate_sel = 4'd0; set_cnt(44'd0); pulse_tick();
    chk("R3 code 0 never sets", per_flag, 0);
    for (int c = 1; c < 16; c++) begin
      int tp = exp_tap(c);
      rate_sel = c[3:0];
      set_cnt(44'd1 << tp);
      pulse_tick();
      chk($sformatf("R4 code %0d match", c), per_flag, 1);
      write_flags(2'b01);
      if (tp > 0) begin
        set_cnt(44'd1 << (tp - 1));
        pulse_tick();
        chk($sformatf("R4 code %0d no match", c), per_flag, 0);
      end
    end
  endtask

  task automatic t_reset_rematch();
    rate_sel = 4'd10;
    set_cnt({32'd7, 12'd0}); pulse_tick();
    chk("R6 first 1 Hz match", per_flag, 1);
    write_flags(2'b01);
    chk("R6 cleared", per_flag, 0);
    set_cnt({32'd8, 12'd0}); pulse_tick();
    chk("R6 sets again next match", per_flag, 1);
    set_cnt({32'd9, 12'd0});
    tick = 1'b1; flag_wr = 1'b1; flag_wdata = 2'b00; step();
    tick = 1'b0; flag_wr = 1'b0; flag_wdata = 2'b11;
    chk("R5 set wins over clear", per_flag, 1);
    write_flags(2'b00);
  endtask

  task automatic t_irq();
    rate_sel = 4'd1; per_ie = 1'b1; step();
    chk("R7 idle irq high", irq_n, 1);
    pulse_tick();
    chk("R7 irq low with periodic", irq_n, 0);
    per_ie = 1'b0; step();
    chk("R7 released when disabled", irq_n, 1);
    rate_sel = 4'd0; write_flags(2'b00);
    alarm_val = 32'd500; sec_cnt = 32'd500; alm_ie = 1'b1;
    cnt_wr = 1'b1; step(); cnt_wr = 1'b0;
    pulse_tick();
    chk("R7 irq low with alarm", irq_n, 0);
    write_flags(2'b10);
    chk("R7 released after clear", irq_n, 1);
    alm_ie = 1'b0;
  endtask

  task automatic t_status();
    osc_stop = 1'b1; upd_busy = 1'b0;
    rate_sel = 4'd1; pulse_tick(); rate_sel = 4'd0;
    chk("R8 status layout A", status, 8'b1000_0010);
    osc_stop = 1'b0; upd_busy = 1'b1; write_flags(2'b00);
    chk("R8 status layout B", status, 8'b0100_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0; step();
    t_reset();
    t_alarm();
    t_rates();
    t_reset_rematch();
    t_irq();
    t_status();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule